// File: doc/BRIEF.md
# PWM Script Loader and Engine Control

This block sits behind a byte-oriented command interface and does two jobs. It loads a 256-word by 16-bit script memory, and it starts and stops three PWM engines. A command is a byte marked as the opcode, followed by parameter bytes. A script write takes three parameter bytes: an address byte, then a high data byte, then a low data byte. Start and stop each take one parameter byte. Every parameter is checked. A rejected parameter raises a one-cycle bad-parameter strobe, and the rest of that command is dropped.

The address byte does two jobs at once. Its two low bits name an engine, where the values 1, 2 and 3 select engines 0, 1 and 2 and the value 0 is invalid. Its six upper bits hold a script address, which may not exceed a limit of 59. For a script write, the whole byte is used as the memory index. The engines read the script through a registered read port. Executing the script is not part of this block. Each engine reports its end with a done pulse, and the block turns that pulse into a status flag at bit 5+n of an 8-bit flag byte.

Top module: `pwm_script_ctl`

## Requirements
- R1: A byte with `byte_first` high is an opcode. 0x95 is script write, 0x96 is start and 0x97 is stop. Parameter bytes that follow any other opcode, or that arrive before any opcode, are ignored and raise no error.
- R2: A write address byte is rejected when bits 1:0 are 00 or when bits 7:2 exceed 59. A rejected byte pulses `bad_param` for exactly the cycle after it is accepted.
- R3: Once a command has ended (after the third write byte, after the start or stop byte, or after a rejected byte), each further parameter byte pulses `bad_param` and changes nothing.
- R4: A valid write address byte becomes the write pointer, using all 8 bits, and clears that memory word.
- R5: The second write byte is OR-ed into bits 15:8 of the word and the third into bits 7:0. A word is read on `rd_data` one cycle after `rd_addr` is presented.
- R6: A start byte that passes the same check as R2 sets engine (bits 1:0)−1 running, with start address bits 7:2, visible the cycle after. A rejected start byte pulses `bad_param` and leaves all engines unchanged.
- R7: Starting an engine that is already running keeps it running and loads the new start address.
- R8: A stop byte with nonzero bits 1:0 halts engine (bits 1:0)−1, whatever bits 7:2 hold. A stop byte with bits 1:0 equal to 00 pulses `bad_param` and halts nothing.
- R9: A done pulse for a running engine n clears its run flag and pulses bit 5+n of `end_flags` for one cycle. A done pulse for an idle engine does nothing. Bits 4:0 of `end_flags` are always 0.
- R10: When a start for engine n and a done for engine n fall in the same cycle, the start wins: the engine stays running with the new address, and the end flag still pulses.
- R11: After reset, all run flags, start addresses, `end_flags` and `bad_param` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A command byte is present this cycle |
| byte_first | input | 1 | The present byte is an opcode |
| byte_data | input | 8 | Command byte |
| eng_done | input | 3 | Per-engine finished pulse |
| rd_addr | input | 8 | Script read address |
| rd_data | output | 16 | Script word, one cycle after rd_addr |
| eng_run | output | 3 | Per-engine running flag |
| eng_start_addr | output | 18 | Start address of engine n in bits 6n+5:6n |
| end_flags | output | 8 | One-cycle finish status, bit 5+n for engine n |
| bad_param | output | 1 | One-cycle bad-parameter strobe |

## Verification
Two events can land on the same engine in the same cycle: the parser's start command and the engine's own done pulse. The bench provokes this by driving the start parameter byte and the done pulse at the same falling edge. It then checks that the run flag stays set, that the start address is the new one and that the end flag still pulses. A stop paired with a done is driven the same way, and the bench checks that the run flag clears with a single end pulse. Around these cases, the bench sweeps all 256 values of the address byte for write, start and stop, and computes the validity and the expected engine state arithmetically.

// File: rtl/pwmld_pkg.sv
package pwmld_pkg;
    localparam logic [7:0] OP_WRITE   = 8'h95;
    localparam logic [7:0] OP_START   = 8'h96;
    localparam logic [7:0] OP_STOP    = 8'h97;
    localparam int         N_ENG      = 3;
    localparam int         SEL_W      = 2;
    localparam int         SADDR_W    = 6;
    localparam int         WORD_W     = 16;
    localparam int         MEM_AW     = 8;
    localparam int         END_BIT0   = 5;
    localparam int         LIMIT_DEF  = 59;

    typedef enum logic [2:0] {
        PS_NONE, PS_WADDR, PS_WHI, PS_WLO, PS_START, PS_STOP, PS_DEAD, PS_IGN
    } pstate_e;

    typedef struct packed {
        logic               start;
        logic               stop;
        logic [SEL_W-1:0]   eng;
        logic [SADDR_W-1:0] saddr;
    } eng_cmd_t;

    function automatic logic sel_ok(input logic [7:0] b);
        return b[SEL_W-1:0] != '0;
    endfunction

    function automatic logic addr_ok(input logic [7:0] b, input int limit);
        return sel_ok(b) && (int'(b[7:SEL_W]) <= limit);
    endfunction

    function automatic logic [SEL_W-1:0] eng_of(input logic [7:0] b);
        return b[SEL_W-1:0] - SEL_W'(1);
    endfunction
endpackage

// File: rtl/pwmld_parser.sv
module pwmld_parser
    import pwmld_pkg::*;
#(
    parameter int ADDR_LIMIT = LIMIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic              byte_first,
    input  logic [7:0]        byte_data,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output eng_cmd_t          cmd,
    output logic              bad_param
);
    pstate_e             state_q, state_d;
    logic [MEM_AW-1:0]   ptr_q, ptr_d;
    logic [WORD_W-1:0]   word_q, word_d;
    logic                err_q, err_d;

    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        word_d    = word_q;
        err_d     = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = ptr_q;
        mem_wdata = word_q;
        cmd       = '0;
        if (byte_valid) begin
            if (byte_first) begin
                case (byte_data)
                    OP_WRITE: state_d = PS_WADDR;
                    OP_START: state_d = PS_START;
                    OP_STOP:  state_d = PS_STOP;
                    default:  state_d = PS_IGN;
                endcase
            end else begin
                case (state_q)
                    PS_WADDR: begin
                        if (addr_ok(byte_data, ADDR_LIMIT)) begin
                            ptr_d     = byte_data;
                            word_d    = '0;
                            mem_we    = 1'b1;
                            mem_waddr = byte_data;
                            mem_wdata = '0;
                            state_d   = PS_WHI;
                        end else begin
                            err_d   = 1'b1;
                            state_d = PS_DEAD;
                        end
                    end
                    PS_WHI: begin
                        word_d    = word_q | {byte_data, 8'h00};
                        mem_we    = 1'b1;
                        mem_wdata = word_d;
                        state_d   = PS_WLO;
                    end
                    PS_WLO: begin
                        word_d    = word_q | {8'h00, byte_data};
                        mem_we    = 1'b1;
                        mem_wdata = word_d;
                        state_d   = PS_DEAD;
                    end
                    PS_START: begin
                        if (addr_ok(byte_data, ADDR_LIMIT)) begin
                            cmd.start = 1'b1;
                            cmd.eng   = eng_of(byte_data);
                            cmd.saddr = byte_data[7:SEL_W];
                        end else begin
                            err_d = 1'b1;
                        end
                        state_d = PS_DEAD;
                    end
                    PS_STOP: begin
                        if (sel_ok(byte_data)) begin
                            cmd.stop = 1'b1;
                            cmd.eng  = eng_of(byte_data);
                        end else begin
                            err_d = 1'b1;
                        end
                        state_d = PS_DEAD;
                    end
                    PS_DEAD: err_d = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_NONE;
            ptr_q   <= '0;
            word_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            word_q  <= word_d;
            err_q   <= err_d;
        end
    end

    assign bad_param = err_q;

    // R3 / R2: an error strobe only follows an accepted parameter byte
    assert_err_follows_param_R3: assert property (@(posedge clk) disable iff (rst)
        bad_param |-> $past(byte_valid && !byte_first));

    // R1: at most one action per accepted byte
    assert_single_action_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, cmd.start, cmd.stop}));

    // R1: opcode bytes never cause actions
    assert_opcode_no_action_R1: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_first) |-> !(mem_we || cmd.start || cmd.stop));
endmodule

// File: rtl/pwmld_mem.sv
module pwmld_mem #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/pwmld_engine.sv
module pwmld_engine #(
    parameter int SADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               stop,
    input  logic               done,
    input  logic [SADDR_W-1:0] saddr_in,
    output logic               run,
    output logic [SADDR_W-1:0] saddr,
    output logic               fin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            saddr <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= done && run;
            if (start) begin
                run   <= 1'b1;
                saddr <= saddr_in;
            end else if (stop || done) begin
                run <= 1'b0;
            end
        end
    end

    // R6 / R7 / R10: a start always leaves the engine running at the new address
    assert_start_loads_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> (run && saddr == $past(saddr_in)));

    // R8: a stop without a start halts the engine
    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !run);

    // R9: a finish flag needs a running engine in the cycle before
    assert_end_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
        fin |-> $past(run && done));
endmodule

// File: rtl/pwm_script_ctl.sv
module pwm_script_ctl
    import pwmld_pkg::*;
#(
    parameter int ADDR_LIMIT = LIMIT_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       byte_valid,
    input  logic                       byte_first,
    input  logic [7:0]                 byte_data,
    input  logic [N_ENG-1:0]           eng_done,
    input  logic [MEM_AW-1:0]          rd_addr,
    output logic [WORD_W-1:0]          rd_data,
    output logic [N_ENG-1:0]           eng_run,
    output logic [N_ENG*SADDR_W-1:0]   eng_start_addr,
    output logic [7:0]                 end_flags,
    output logic                       bad_param
);
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;
    eng_cmd_t          cmd;
    logic [N_ENG-1:0]  fin;

    pwmld_parser #(.ADDR_LIMIT(ADDR_LIMIT)) u_parser (
        .clk(clk), .rst(rst),
        .byte_valid(byte_valid), .byte_first(byte_first), .byte_data(byte_data),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .cmd(cmd), .bad_param(bad_param)
    );

    pwmld_mem #(.AW(MEM_AW), .DW(WORD_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    for (genvar n = 0; n < N_ENG; n++) begin : g_eng
        pwmld_engine #(.SADDR_W(SADDR_W)) u_eng (
            .clk(clk), .rst(rst),
            .start(cmd.start && cmd.eng == SEL_W'(n)),
            .stop(cmd.stop && cmd.eng == SEL_W'(n)),
            .done(eng_done[n]),
            .saddr_in(cmd.saddr),
            .run(eng_run[n]),
            .saddr(eng_start_addr[n*SADDR_W +: SADDR_W]),
            .fin(fin[n])
        );
    end

    always_comb begin
        end_flags = '0;
        end_flags[END_BIT0 +: N_ENG] = fin;
    end

    // R9: flag bits below the end field stay clear
    assert_low_flags_clear_R9: assert property (@(posedge clk) disable iff (rst)
        end_flags[END_BIT0-1:0] == '0);
endmodule

// File: tb/pwm_script_ctl_tb.sv
`timescale 1ns/1ps
module pwm_script_ctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_valid = 1'b0;
    logic        byte_first = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [2:0]  eng_done = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  eng_run;
    logic [17:0] eng_start_addr;
    logic [7:0]  end_flags;
    logic        bad_param;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [2:0]  exp_run;
    logic [5:0]  exp_addr [3];

    always #2.5 clk = ~clk;

    pwm_script_ctl u_dut (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_first(byte_first),
        .byte_data(byte_data), .eng_done(eng_done), .rd_addr(rd_addr),
        .rd_data(rd_data), .eng_run(eng_run), .eng_start_addr(eng_start_addr),
        .end_flags(end_flags), .bad_param(bad_param)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic v, input logic first, input logic [7:0] b,
                        input logic [2:0] dn);
        @(negedge clk);
        byte_valid = v; byte_first = first; byte_data = b; eng_done = dn;
        @(negedge clk);
        byte_valid = 1'b0; byte_first = 1'b0; eng_done = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic chk_engines(input string req);
        for (int n = 0; n < 3; n++) begin
            chk(eng_run[n] == exp_run[n], req, eng_run, exp_run);
            if (exp_run[n])
                chk(eng_start_addr[n*6 +: 6] == exp_addr[n], req,
                    eng_start_addr[n*6 +: 6], exp_addr[n]);
        end
    endtask

    function automatic bit valid_addr(input logic [7:0] b);
        return (b[1:0] != 2'b00) && (b[7:2] <= 6'd59);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  hi, lo;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(eng_run == 3'b000, "R11 run", eng_run, 0);
        chk(eng_start_addr == '0, "R11 addr", eng_start_addr, 0);
        chk(end_flags == 8'h00, "R11 flags", end_flags, 0);
        chk(bad_param == 1'b0, "R11 err", bad_param, 0);

        // R1: parameter before any opcode, and after an unknown opcode
        xfer(1, 0, 8'h05, 0);
        chk(bad_param == 0, "R1 no opcode", bad_param, 0);
        xfer(1, 1, 8'h80, 0);
        xfer(1, 0, 8'h00, 0);
        chk(bad_param == 0, "R1 unknown op", bad_param, 0);
        chk(eng_run == 0, "R1 unknown op run", eng_run, 0);

        // R2 R4 R5: two sweeps of every address byte; the second proves clearing
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 256; a++) begin
                hi = 8'(a) ^ (p == 0 ? 8'h3C : 8'hC3);
                lo = ~8'(a) ^ 8'(p);
                xfer(1, 1, 8'h95, 0);
                xfer(1, 0, 8'(a), 0);
                chk(bad_param == !valid_addr(8'(a)), "R2 addr check", bad_param,
                    !valid_addr(8'(a)));
                if (valid_addr(8'(a))) begin
                    xfer(1, 0, hi, 0);
                    xfer(1, 0, lo, 0);
                    chk(bad_param == 0, "R5 data err", bad_param, 0);
                    rd(8'(a), d);
                    chk(d == {hi, lo}, "R4 R5 word", d, {hi, lo});
                end
            end
        end

        // R3: extra byte after a complete write
        xfer(1, 1, 8'h95, 0); xfer(1, 0, 8'h05, 0);
        xfer(1, 0, 8'h12, 0); xfer(1, 0, 8'h34, 0);
        xfer(1, 0, 8'hFF, 0);
        chk(bad_param == 1, "R3 extra write byte", bad_param, 1);
        rd(8'h05, d);
        chk(d == 16'h1234, "R3 word unchanged", d, 16'h1234);
        // R3: bytes after a rejected address
        xfer(1, 1, 8'h95, 0); xfer(1, 0, 8'hF1, 0);
        chk(bad_param == 1, "R2 limit 60", bad_param, 1);
        xfer(1, 0, 8'h77, 0);
        chk(bad_param == 1, "R3 after reject", bad_param, 1);
        @(negedge clk);
        chk(bad_param == 0, "R2 strobe one cycle", bad_param, 0);

        // R6 R7: sweep all start bytes
        exp_run = '0;
        for (int n = 0; n < 3; n++) exp_addr[n] = '0;
        for (int b = 0; b < 256; b++) begin
            xfer(1, 1, 8'h96, 0);
            xfer(1, 0, 8'(b), 0);
            chk(bad_param == !valid_addr(8'(b)), "R6 start check", bad_param,
                !valid_addr(8'(b)));
            if (valid_addr(8'(b))) begin
                exp_run[b % 4 - 1] = 1'b1;
                exp_addr[b % 4 - 1] = 6'(b / 4);
            end
            chk_engines("R6 R7 start state");
        end
        // R3: extra byte after start
        xfer(1, 0, 8'h05, 0);
        chk(bad_param == 1, "R3 extra start byte", bad_param, 1);
        chk_engines("R3 start unchanged");

        // R8: sweep all stop bytes, restarting all engines each time
        for (int b = 0; b < 256; b++) begin
            for (int n = 0; n < 3; n++) begin
                xfer(1, 1, 8'h96, 0);
                xfer(1, 0, {6'(n + 10), 2'(n + 1)}, 0);
                exp_run[n] = 1'b1; exp_addr[n] = 6'(n + 10);
            end
            xfer(1, 1, 8'h97, 0);
            xfer(1, 0, 8'(b), 0);
            chk(bad_param == (b % 4 == 0), "R8 stop check", bad_param, b % 4 == 0);
            if (b % 4 != 0) exp_run[b % 4 - 1] = 1'b0;
            chk_engines("R8 stop state");
        end

        // R9: done on running and idle engines
        for (int n = 0; n < 3; n++) begin
            xfer(1, 1, 8'h97, 0); xfer(1, 0, 8'(n + 1), 0);
        end
        xfer(0, 0, 8'h00, 3'b010);
        chk(end_flags == 8'h00, "R9 idle done", end_flags, 0);
        xfer(1, 1, 8'h96, 0); xfer(1, 0, {6'd7, 2'd2}, 0);
        xfer(0, 0, 8'h00, 3'b010);
        chk(end_flags == 8'h40, "R9 end flag", end_flags, 8'h40);
        chk(eng_run == 3'b000, "R9 run cleared", eng_run, 0);
        @(negedge clk);
        chk(end_flags == 8'h00, "R9 flag one cycle", end_flags, 0);
        xfer(1, 1, 8'h96, 0); xfer(1, 0, {6'd1, 2'd1}, 0);
        xfer(1, 1, 8'h96, 0); xfer(1, 0, {6'd2, 2'd3}, 0);
        xfer(0, 0, 8'h00, 3'b101);
        chk(end_flags == 8'hA0, "R9 two flags", end_flags, 8'hA0);

        // R10: start and done on the same engine in one cycle
        xfer(1, 1, 8'h96, 0); xfer(1, 0, {6'd20, 2'd3}, 0);
        xfer(1, 1, 8'h96, 0);
        xfer(1, 0, {6'd33, 2'd3}, 3'b100);
        chk(eng_run[2] == 1, "R10 start wins run", eng_run, 3'b100);
        chk(eng_start_addr[17:12] == 6'd33, "R10 new addr", eng_start_addr[17:12], 33);
        chk(end_flags == 8'h80, "R10 end pulse", end_flags, 8'h80);
        // R10: stop and done together
        xfer(1, 1, 8'h97, 0);
        xfer(1, 0, 8'h03, 3'b100);
        chk(eng_run[2] == 0, "R10 stop+done run", eng_run, 0);
        chk(end_flags == 8'h80, "R10 stop+done pulse", end_flags, 8'h80);
        @(negedge clk);
        chk(end_flags == 8'h00, "R10 single pulse", end_flags, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule